// File: doc/BRIEF.md
# E1 Receive Multiframe Descriptor Engine

This block places received E1 multiframes into a shared byte buffer, one receive channel per instance. Software loads buffer descriptors through a register write. Each descriptor carries a 7-bit multiframe slot number, and the block holds them in a small input queue. Framing and CRC-4 checking happen upstream. They deliver an alignment flag, a strobe at each multiframe boundary, byte strobes tagged with a frame and timeslot index, and two CRC pass flags, one for each half of the multiframe.

When an aligned multiframe begins, the engine takes the oldest queued descriptor and writes all 512 bytes of the multiframe (16 frames of 32 timeslots) into the slot that descriptor names. After the last byte it pushes a completed descriptor into an output queue. The completed descriptor has its valid flag set and carries both CRC results. Software drains the output queue by reading the descriptor register. A multiframe that finds no descriptor waiting, or finds no room for its result, is dropped and sets a sticky overflow flag. A loss of alignment partway through a multiframe discards it.

Top module: `rxmf_desc_engine`

## Requirements
- R1: After reset the receiver is disabled, both queues are empty, the status word reads 0x0500, a descriptor read returns 0 and no buffer write is issued.
- R2: Register address 0 is control/status. A write sets enable from bit 0 and the mode from bits 2:1 (3 = multiframe aligned). A read returns enable in bit 0 and, in bit 1, the alignment input ANDed with enable.
- R3: A write to register address 1 queues bits 6:0 as a multiframe slot. The input queue holds 4 entries, and a write to a full queue is ignored. Status bit 8 reports that the input queue is empty and bit 9 that it is full.
- R4: A multiframe is captured only if, at its start strobe, the engine is enabled, the mode is 3 and the alignment input is high. Any other start leaves the queues, the overflow flag and the buffer untouched.
- R5: Each captured byte is written to buffer address {slot[6:0], frame[3:0], timeslot[4:0]} with its data unchanged, one clock after its strobe.
- R6: The byte at frame 15, timeslot 31 completes the multiframe. A descriptor is then pushed with bit 15 = 1, bit 14 = CRC flag of the second half, bit 13 = CRC flag of the first half and bits 6:0 = slot. The CRC flags are sampled with that byte.
- R7: A read of register address 1 returns, one clock later, the oldest completed descriptor and removes it from the queue. When the output queue is empty the read returns 0 and removes nothing. Status bit 10 reports that the output queue is empty and bit 11 that it is full.
- R8: A start that qualifies under R4 but finds the input queue empty or the output queue full writes nothing, consumes no descriptor and sets status bit 12, which stays set.
- R9: Writing address 0 with bit 12 = 1 clears the overflow flag.
- R10: Loss of alignment during a multiframe stops the capture at once. The slot is consumed and no descriptor is produced for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 1 | 0 = control/status, 1 = descriptor |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Registered read data, valid the clock after reg_rd |
| rx_aligned | input | 1 | Multiframe alignment held by the framer |
| rx_mf_start | input | 1 | Start-of-multiframe strobe |
| rx_byte_vld | input | 1 | Received byte strobe |
| rx_frame | input | 4 | Frame index of the byte within the multiframe |
| rx_ts | input | 5 | Timeslot index of the byte |
| rx_byte | input | 8 | Received byte |
| rx_crc_ok | input | 2 | CRC pass flags, bit 0 first half, bit 1 second half |
| buf_we | output | 1 | Buffer write enable |
| buf_addr | output | 16 | Buffer byte address |
| buf_wdata | output | 8 | Buffer write data |

## Verification
Some cases are hard to reach from the ports. The overflow that comes from a full output queue needs four completed multiframes left unread, plus a fifth descriptor pending, before one more start strobe arrives. The bench reaches it by filling the input queue, playing four complete multiframes and only then reading anything back. The same fill sequence shows that a fifth push to a full input queue is discarded. Loss of alignment is forced at byte 100 of a multiframe; the bench then confirms that exactly 100 writes landed and that no descriptor was produced. A start strobe with alignment low is shown to leave a queued slot in place by capturing into that slot afterwards.

// File: rtl/rxmf_pkg.sv
package rxmf_pkg;
  localparam int MF_W   = 7;
  localparam int FRM_W  = 4;
  localparam int TS_W   = 5;
  localparam int BUF_AW = MF_W + FRM_W + TS_W;
  localparam int REG_W  = 16;

  // descriptor bit positions
  localparam int D_VALID = 15;
  localparam int D_CRC_B = 14;
  localparam int D_CRC_A = 13;

  // control bit positions
  localparam int C_EN    = 0;
  localparam int C_MODE  = 1;
  localparam int C_CLR   = 12;

  // status bit positions
  localparam int S_EN     = 0;
  localparam int S_ALIGN  = 1;
  localparam int S_IEMPTY = 8;
  localparam int S_IFULL  = 9;
  localparam int S_OEMPTY = 10;
  localparam int S_OFULL  = 11;
  localparam int S_OVF    = 12;

  typedef enum logic [1:0] {
    MODE_RAW   = 2'd0,
    MODE_OCTET = 2'd1,
    MODE_FRAME = 2'd2,
    MODE_MULTI = 2'd3
  } rx_mode_e;
endpackage

// File: rtl/rxmf_desc_fifo.sv
module rxmf_desc_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          push_ok, pop_ok;

  assign empty   = (cnt == '0);
  assign full    = (cnt == FULL_CNT);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push_ok) wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (pop_ok)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/rxmf_capture.sv
module rxmf_capture
  import rxmf_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              run_mfa,
  input  logic              aligned,
  input  logic              mf_start,
  input  logic              byte_vld,
  input  logic [FRM_W-1:0]  frame,
  input  logic [TS_W-1:0]   ts,
  input  logic [7:0]        byte_in,
  input  logic [1:0]        crc_ok,
  input  logic              in_empty,
  input  logic [MF_W-1:0]   in_head,
  input  logic              out_full,
  output logic              in_pop,
  output logic              out_push,
  output logic [REG_W-1:0]  out_desc,
  output logic              ovf_set,
  output logic              buf_we,
  output logic [BUF_AW-1:0] buf_addr,
  output logic [7:0]        buf_wdata
);
  logic            act_q;
  logic [MF_W-1:0] slot_q;
  logic            start_req, start_ok, cap_now, last_byte;
  logic [MF_W-1:0] slot_now;

  assign start_req = mf_start && aligned && run_mfa;
  assign start_ok  = start_req && !in_empty && !out_full;
  assign ovf_set   = start_req && (in_empty || out_full);
  assign in_pop    = start_ok;
  // a fresh start strobe always ends an unfinished capture
  assign cap_now   = start_ok || (act_q && aligned && run_mfa && !mf_start);
  assign slot_now  = start_ok ? in_head : slot_q;
  assign last_byte = byte_vld && (frame == '1) && (ts == '1);
  assign out_push  = cap_now && last_byte;

  always_comb begin
    out_desc            = '0;
    out_desc[D_VALID]   = 1'b1;
    out_desc[D_CRC_B]   = crc_ok[1];
    out_desc[D_CRC_A]   = crc_ok[0];
    out_desc[MF_W-1:0]  = slot_now;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= 1'b0;
      slot_q <= '0;
      buf_we <= 1'b0;
    end else begin
      act_q  <= cap_now && !last_byte;
      slot_q <= slot_now;
      buf_we <= cap_now && byte_vld;
    end
  end

  always_ff @(posedge clk) begin
    buf_addr  <= {slot_now, frame, ts};
    buf_wdata <= byte_in;
  end
endmodule

// File: rtl/rxmf_desc_engine.sv
module rxmf_desc_engine
  import rxmf_pkg::*;
#(
  parameter int QDEPTH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic              reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              rx_aligned,
  input  logic              rx_mf_start,
  input  logic              rx_byte_vld,
  input  logic [FRM_W-1:0]  rx_frame,
  input  logic [TS_W-1:0]   rx_ts,
  input  logic [7:0]        rx_byte,
  input  logic [1:0]        rx_crc_ok,
  output logic              buf_we,
  output logic [BUF_AW-1:0] buf_addr,
  output logic [7:0]        buf_wdata
);
  logic            en_q, ovfl_q;
  rx_mode_e        mode_q;
  logic            in_push, in_pop, in_empty, in_full;
  logic [MF_W-1:0] in_head;
  logic            out_push, out_pop, out_empty, out_full;
  logic [REG_W-1:0] out_desc, out_head;
  logic            ovf_set, ctl_wr, ovf_clr;
  logic [REG_W-1:0] status;
  logic            unused_bits;

  assign unused_bits = ^{reg_wdata[15:13], reg_wdata[11:7]};

  assign ctl_wr  = reg_wr && !reg_addr;
  assign ovf_clr = ctl_wr && reg_wdata[C_CLR];
  assign in_push = reg_wr && reg_addr;
  assign out_pop = reg_rd && reg_addr && !out_empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      mode_q <= MODE_RAW;
      ovfl_q <= 1'b0;
    end else begin
      if (ctl_wr) begin
        en_q   <= reg_wdata[C_EN];
        mode_q <= rx_mode_e'(reg_wdata[C_MODE +: 2]);
      end
      if (ovf_set)      ovfl_q <= 1'b1;
      else if (ovf_clr) ovfl_q <= 1'b0;
    end
  end

  always_comb begin
    status           = '0;
    status[S_EN]     = en_q;
    status[S_ALIGN]  = en_q && rx_aligned;
    status[S_IEMPTY] = in_empty;
    status[S_IFULL]  = in_full;
    status[S_OEMPTY] = out_empty;
    status[S_OFULL]  = out_full;
    status[S_OVF]    = ovfl_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      if (!reg_addr)      reg_rdata <= status;
      else if (out_empty) reg_rdata <= '0;
      else                reg_rdata <= out_head;
    end
  end

  rxmf_desc_fifo #(.W(MF_W), .DEPTH(QDEPTH)) in_q_i (
    .clk(clk), .rst(rst), .push(in_push), .din(reg_wdata[MF_W-1:0]),
    .pop(in_pop), .dout(in_head), .empty(in_empty), .full(in_full)
  );

  rxmf_desc_fifo #(.W(REG_W), .DEPTH(QDEPTH)) out_q_i (
    .clk(clk), .rst(rst), .push(out_push), .din(out_desc),
    .pop(out_pop), .dout(out_head), .empty(out_empty), .full(out_full)
  );

  rxmf_capture cap_i (
    .clk(clk), .rst(rst),
    .run_mfa(en_q && (mode_q == MODE_MULTI)),
    .aligned(rx_aligned), .mf_start(rx_mf_start),
    .byte_vld(rx_byte_vld), .frame(rx_frame), .ts(rx_ts),
    .byte_in(rx_byte), .crc_ok(rx_crc_ok),
    .in_empty(in_empty), .in_head(in_head), .out_full(out_full),
    .in_pop(in_pop), .out_push(out_push), .out_desc(out_desc),
    .ovf_set(ovf_set), .buf_we(buf_we), .buf_addr(buf_addr),
    .buf_wdata(buf_wdata)
  );
endmodule

// File: rtl/rxmf_desc_engine_chk.sv
module rxmf_desc_engine_chk (
  input logic        clk,
  input logic        rst,
  input logic        reg_wr,
  input logic        reg_rd,
  input logic        reg_addr,
  input logic [15:0] reg_wdata,
  input logic [15:0] reg_rdata,
  input logic        rx_byte_vld,
  input logic        buf_we,
  input logic        en_q,
  input logic        ovfl_q,
  input logic        in_empty,
  input logic        in_full,
  input logic        out_empty,
  input logic        out_push,
  input logic        out_full
);
  // R8
  ovfl_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (ovfl_q && !(reg_wr && !reg_addr && reg_wdata[12])) |=> ovfl_q);

  // R7
  empty_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr && out_empty) |=> (reg_rdata == 16'h0000));

  // R5
  write_follows_byte_chk: assert property (@(posedge clk) disable iff (rst)
    buf_we |-> $past(rx_byte_vld));

  // R4
  write_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
    buf_we |-> $past(en_q));

  // R6
  no_push_when_full_chk: assert property (@(posedge clk) disable iff (rst)
    out_push |-> !out_full);

  // R3
  in_queue_flags_chk: assert property (@(posedge clk) disable iff (rst)
    !(in_full && in_empty));
endmodule

bind rxmf_desc_engine rxmf_desc_engine_chk chk_i (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .rx_byte_vld(rx_byte_vld), .buf_we(buf_we), .en_q(en_q),
  .ovfl_q(ovfl_q), .in_empty(in_empty), .in_full(in_full),
  .out_empty(out_empty), .out_push(out_push), .out_full(out_full)
);

// File: tb/rxmf_desc_engine_tb_top.sv
module rxmf_desc_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG = 150000;
  localparam int NVEC = 6;
  // {crc[1:0], slot[6:0]}
  localparam logic [8:0] VEC [NVEC] = '{
    {2'd3, 7'd5}, {2'd0, 7'd127}, {2'd1, 7'd0},
    {2'd2, 7'd64}, {2'd3, 7'd33}, {2'd1, 7'd90}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 0, reg_rd = 0, reg_addr = 0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic rx_aligned = 1'b1, rx_mf_start = 0, rx_byte_vld = 0;
  logic [3:0] rx_frame = '0;
  logic [4:0] rx_ts = '0;
  logic [7:0] rx_byte = '0;
  logic [1:0] rx_crc_ok = '0;
  logic buf_we;
  logic [15:0] buf_addr;
  logic [7:0] buf_wdata;

  int n_chk = 0, n_bad = 0, wr_count = 0, cycles = 0;
  logic [6:0] exp_mf = '0;
  logic [15:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  rxmf_desc_engine dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rx_aligned(rx_aligned), .rx_mf_start(rx_mf_start),
    .rx_byte_vld(rx_byte_vld), .rx_frame(rx_frame), .rx_ts(rx_ts),
    .rx_byte(rx_byte), .rx_crc_ok(rx_crc_ok), .buf_we(buf_we),
    .buf_addr(buf_addr), .buf_wdata(buf_wdata)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // R5: address and data of every buffer write
  always @(negedge clk) begin
    if (!rst && buf_we) begin
      logic [8:0] idx;
      idx = wr_count[8:0];
      chk(buf_addr == {exp_mf, idx}, "R5 addr", buf_addr, {exp_mf, idx});
      chk(buf_wdata == (idx[7:0] ^ {1'b0, exp_mf}), "R5 data", buf_wdata,
          idx[7:0] ^ {1'b0, exp_mf});
      wr_count++;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WDOG) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected<%0d", cycles, WDOG);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic reg_write(input logic a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic reg_read(input logic a, output logic [15:0] d);
    @(negedge clk);
    reg_rd = 1; reg_addr = a;
    @(negedge clk);
    reg_rd = 0;
    d = reg_rdata;
  endtask

  task automatic chk_stat(input logic [15:0] e, input string tag);
    logic [15:0] v;
    reg_read(1'b0, v);
    chk(v == e, tag, v, e);
  endtask

  task automatic chk_desc(input logic [15:0] e, input string tag);
    logic [15:0] v;
    reg_read(1'b1, v);
    chk(v == e, tag, v, e);
  endtask

  // plays one multiframe; alignment drops at byte abort_at (-1 = never)
  task automatic run_mf(input logic [1:0] crc, input int abort_at);
    wr_count = 0;
    @(negedge clk);
    rx_mf_start = 1;
    @(negedge clk);
    rx_mf_start = 0;
    for (int i = 0; i < 512; i++) begin
      if (i == abort_at) rx_aligned = 0;
      rx_byte_vld = 1;
      rx_frame = i[8:5];
      rx_ts = i[4:0];
      rx_byte = i[7:0] ^ {1'b0, exp_mf};
      rx_crc_ok = (i == 511) ? crc : ~crc;
      @(negedge clk);
    end
    rx_byte_vld = 0;
    @(negedge clk);
    @(negedge clk);
    rx_aligned = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk(buf_we == 1'b0, "R1 buf_we", buf_we, 0);
    chk_stat(16'h0500, "R1 status");
    chk_desc(16'h0000, "R1 desc");

    // R2 enable in multiframe mode
    reg_write(1'b0, 16'h0007);
    chk_stat(16'h0503, "R2 status enabled");

    // table walk: R5 writes, R6 descriptor content, R7 drain
    for (int v = 0; v < NVEC; v++) begin
      exp_mf = VEC[v][6:0];
      reg_write(1'b1, {9'd0, VEC[v][6:0]});
      run_mf(VEC[v][8:7], -1);
      chk(wr_count == 512, "R5 write count", wr_count, 512);
      chk_desc(16'h8000 | ({14'd0, VEC[v][8:7]} << 13) | {9'd0, VEC[v][6:0]},
               "R6 descriptor");
      chk_stat(16'h0503, "R7 drained");
    end

    // R3 fill input queue, fifth push ignored
    for (int k = 0; k < 4; k++) reg_write(1'b1, 16'(10 + k));
    chk_stat(16'h0603, "R3 input full");
    reg_write(1'b1, 16'd14);
    for (int k = 0; k < 4; k++) begin
      exp_mf = 7'(10 + k);
      run_mf(2'b11, -1);
    end
    chk_stat(16'h0903, "R3 R7 out full in empty");

    // R8 overflow on full output queue
    reg_write(1'b1, 16'd20);
    run_mf(2'b11, -1);
    chk(wr_count == 0, "R8 no writes", wr_count, 0);
    chk_stat(16'h1803, "R8 overflow out full");
    for (int k = 0; k < 4; k++) chk_desc(16'hE000 | 16'(10 + k), "R7 order");
    chk_desc(16'h0000, "R7 empty read");
    chk_stat(16'h1403, "R8 sticky, slot kept");

    // R9 clear
    reg_write(1'b0, 16'h1007);
    chk_stat(16'h0403, "R9 cleared");

    // R10 alignment loss at byte 100
    exp_mf = 7'd20;
    run_mf(2'b11, 100);
    chk(wr_count == 100, "R10 partial writes", wr_count, 100);
    chk_desc(16'h0000, "R10 no descriptor");
    chk_stat(16'h0503, "R10 slot consumed");

    // R8 overflow on empty input queue
    run_mf(2'b11, -1);
    chk(wr_count == 0, "R8 empty in writes", wr_count, 0);
    chk_stat(16'h1503, "R8 overflow in empty");
    reg_write(1'b0, 16'h1007);

    // R4 wrong mode
    reg_write(1'b0, 16'h0005);
    reg_write(1'b1, 16'd30);
    exp_mf = 7'd30;
    run_mf(2'b01, -1);
    chk(wr_count == 0, "R4 mode writes", wr_count, 0);
    chk_stat(16'h0403, "R4 mode status");

    // R2 R4 disabled
    reg_write(1'b0, 16'h0006);
    chk_stat(16'h0400, "R2 disabled status");
    run_mf(2'b01, -1);
    chk(wr_count == 0, "R4 disabled writes", wr_count, 0);

    // R4 start without alignment
    reg_write(1'b0, 16'h0007);
    rx_aligned = 0;
    chk_stat(16'h0401, "R2 align low");
    @(negedge clk); rx_mf_start = 1;
    @(negedge clk); rx_mf_start = 0;
    chk_stat(16'h0401, "R4 unaligned start ignored");
    rx_aligned = 1;
    run_mf(2'b01, -1);
    chk(wr_count == 512, "R4 slot retained", wr_count, 512);
    chk_desc(16'hA01E, "R6 crc first only");

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule